// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the effective address of a memory operand from up to three terms: a base register value, an index register value shifted left by a scale code, and a displacement. Two addressing modes exist. The wide mode produces a full-width address from any base register, a scaled index, and a displacement that is absent, one byte or full width. The narrow legacy mode uses a restricted set of base and index registers, allows no scaling, and wraps the result to 16 bits.

Beside the address the block reports which segment the operand uses by default, selected from the base register, and raises an error when the register choice or the field codes break the rules of the chosen mode. When the error is raised the address is don't-care. The result is registered, so every output follows its inputs by one clock. Instruction decoding, register file reads and segment translation are done outside this block.

Register selectors use a 3-bit code: 0 A, 1 C, 2 D, 3 B, 4 stack pointer, 5 frame pointer, 6 source index, 7 destination index.

Top module: `ea_gen`

## Requirements
- R1: With wide_mode_i=1 and no error, ea_o one clock after the inputs equals base + (index << scale_i) + displacement, modulo 2^32; a term whose valid bit is 0 adds zero.
- R2: disp_sz_i code 0 adds no displacement, code 1 adds disp_i[7:0] sign-extended, code 2 adds disp_i at full width in wide mode and disp_i[15:0] in narrow mode, and code 3 raises err_o.
- R3: In wide mode any of the eight registers may be the base, but a valid index with selector 4 (stack pointer) raises err_o.
- R4: In narrow mode (wide_mode_i=0) a valid base other than selector 3 or 5, or a valid index other than selector 6 or 7, raises err_o.
- R5: A nonzero scale_i raises err_o when in narrow mode or when no index is valid.
- R6: In narrow mode with no error, ea_o[15:0] is the sum of the 16-bit base, index and displacement terms modulo 2^16 and ea_o[31:16] is zero.
- R7: seg_o is 1 (stack segment) when a valid base has selector 4 or 5, and 0 (data segment) otherwise, including when no base is valid.
- R8: While rst_n is low, ea_o, seg_o and err_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the output register |
| wide_mode_i | input | 1 | 1 selects wide mode, 0 the narrow 16-bit mode |
| base_vld_i | input | 1 | A base register takes part |
| base_sel_i | input | 3 | Base register selector |
| idx_vld_i | input | 1 | An index register takes part |
| idx_sel_i | input | 3 | Index register selector |
| scale_i | input | 2 | Index shift: 0..3 for factors 1, 2, 4, 8 |
| disp_i | input | 32 | Displacement field |
| disp_sz_i | input | 2 | Displacement size code |
| base_val_i | input | 32 | Value of the base register |
| idx_val_i | input | 32 | Value of the index register |
| ea_o | output | 32 | Effective address |
| seg_o | output | 1 | Default segment: 0 data, 1 stack |
| err_o | output | 1 | Illegal register or field combination |

## Verification
A fault in the legality logic shows on err_o one clock after the offending operand, either as a missed error for a stack-pointer index or as a false error on a legal narrow base, so the random mix of both modes exposes it in the first few hundred operands. A wrong shift, sign extension or wrap shows as a wrong ea_o in the same cycle's result, with narrow-mode faults often visible only in the upper sixteen bits. A segment decode fault shows on seg_o for frame-pointer and stack-pointer bases, which the directed cases hit early.

// File: rtl/ea_pkg.sv
package ea_pkg;
   localparam int REG_W   = 3;
   localparam int SCALE_W = 2;

   localparam logic [REG_W-1:0] SEL_B  = 3'd3;
   localparam logic [REG_W-1:0] SEL_SP = 3'd4;
   localparam logic [REG_W-1:0] SEL_BP = 3'd5;
   localparam logic [REG_W-1:0] SEL_SI = 3'd6;
   localparam logic [REG_W-1:0] SEL_DI = 3'd7;

   typedef enum logic [1:0] {
      DSZ_NONE = 2'd0,
      DSZ_BYTE = 2'd1,
      DSZ_FULL = 2'd2,
      DSZ_RSVD = 2'd3
   } dsz_e;

   typedef enum logic {
      SEG_DATA  = 1'b0,
      SEG_STACK = 1'b1
   } seg_e;
endpackage

// File: rtl/ea_disp_ext.sv
module ea_disp_ext
   import ea_pkg::*;
#(
   parameter int AW = 32,
   parameter int NW = 16
) (
   input  logic          wide_i,
   input  logic [1:0]    sz_i,
   input  logic [AW-1:0] disp_i,
   output logic [AW-1:0] ext_o,
   output logic          bad_o
);
   localparam int BYTE_W = 8;

   logic [AW-1:0] byte_ext;
   logic [AW-1:0] narrow_ext;

   assign byte_ext   = {{(AW-BYTE_W){disp_i[BYTE_W-1]}}, disp_i[BYTE_W-1:0]};
   assign narrow_ext = {{(AW-NW){1'b0}}, disp_i[NW-1:0]};

   always_comb begin
      bad_o = 1'b0;
      unique case (dsz_e'(sz_i))
         DSZ_NONE: ext_o = '0;
         DSZ_BYTE: ext_o = byte_ext;
         DSZ_FULL: ext_o = wide_i ? disp_i : narrow_ext;
         default: begin
            ext_o = '0;
            bad_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/ea_reg_check.sv
module ea_reg_check
   import ea_pkg::*;
(
   input  logic               wide_i,
   input  logic               base_v_i,
   input  logic [REG_W-1:0]   base_sel_i,
   input  logic               idx_v_i,
   input  logic [REG_W-1:0]   idx_sel_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic               illegal_o,
   output logic               stack_o
);
   logic narrow_base_ok;
   logic narrow_idx_ok;
   logic wide_idx_bad;
   logic scale_bad;

   assign narrow_base_ok = (base_sel_i == SEL_B) || (base_sel_i == SEL_BP);
   assign narrow_idx_ok  = (idx_sel_i == SEL_SI) || (idx_sel_i == SEL_DI);
   assign wide_idx_bad   = idx_v_i && (idx_sel_i == SEL_SP);
   assign scale_bad      = (scale_i != '0) && (!wide_i || !idx_v_i);

   always_comb begin
      if (wide_i)
         illegal_o = wide_idx_bad || scale_bad;
      else
         illegal_o = (base_v_i && !narrow_base_ok) ||
                     (idx_v_i && !narrow_idx_ok) || scale_bad;
   end

   assign stack_o = base_v_i && ((base_sel_i == SEL_SP) || (base_sel_i == SEL_BP));
endmodule

// File: rtl/ea_sum.sv
module ea_sum
   import ea_pkg::*;
#(
   parameter int AW = 32,
   parameter int NW = 16
) (
   input  logic               wide_i,
   input  logic               base_v_i,
   input  logic [AW-1:0]      base_val_i,
   input  logic               idx_v_i,
   input  logic [AW-1:0]      idx_val_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [AW-1:0]      disp_i,
   output logic [AW-1:0]      ea_o
);
   logic [AW-1:0] base_term;
   logic [AW-1:0] idx_term;
   logic [AW-1:0] full_sum;

   assign base_term = base_v_i ? base_val_i : '0;
   assign idx_term  = idx_v_i ? (idx_val_i << scale_i) : '0;
   assign full_sum  = base_term + idx_term + disp_i;

   assign ea_o = wide_i ? full_sum : {{(AW-NW){1'b0}}, full_sum[NW-1:0]};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
   import ea_pkg::*;
#(
   parameter int AW      = 32,
   parameter int NW      = 16,
   parameter bit REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wide_mode_i,
   input  logic               base_vld_i,
   input  logic [REG_W-1:0]   base_sel_i,
   input  logic               idx_vld_i,
   input  logic [REG_W-1:0]   idx_sel_i,
   input  logic [SCALE_W-1:0] scale_i,
   input  logic [AW-1:0]      disp_i,
   input  logic [1:0]         disp_sz_i,
   input  logic [AW-1:0]      base_val_i,
   input  logic [AW-1:0]      idx_val_i,
   output logic [AW-1:0]      ea_o,
   output logic               seg_o,
   output logic               err_o
);
   if (NW < 8 || NW >= AW) begin : g_bad_widths
      $error("ea_gen: NW must be at least 8 and below AW");
   end

   logic [AW-1:0] disp_ext;
   logic          disp_bad;
   logic          reg_bad;
   logic          stack_c;
   logic [AW-1:0] ea_c;
   logic          err_c;

   ea_disp_ext #(.AW(AW), .NW(NW)) i_disp (
      .wide_i (wide_mode_i),
      .sz_i   (disp_sz_i),
      .disp_i (disp_i),
      .ext_o  (disp_ext),
      .bad_o  (disp_bad)
   );

   ea_reg_check i_check (
      .wide_i     (wide_mode_i),
      .base_v_i   (base_vld_i),
      .base_sel_i (base_sel_i),
      .idx_v_i    (idx_vld_i),
      .idx_sel_i  (idx_sel_i),
      .scale_i    (scale_i),
      .illegal_o  (reg_bad),
      .stack_o    (stack_c)
   );

   ea_sum #(.AW(AW), .NW(NW)) i_sum (
      .wide_i     (wide_mode_i),
      .base_v_i   (base_vld_i),
      .base_val_i (base_val_i),
      .idx_v_i    (idx_vld_i),
      .idx_val_i  (idx_val_i),
      .scale_i    (scale_i),
      .disp_i     (disp_ext),
      .ea_o       (ea_c)
   );

   assign err_c = reg_bad || disp_bad;

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ea_o  <= '0;
            seg_o <= SEG_DATA;
            err_o <= 1'b0;
         end else begin
            ea_o  <= ea_c;
            seg_o <= stack_c;
            err_o <= err_c;
         end
      end

      // R3: a stack-pointer index in wide mode is refused
      assert_sp_index_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (wide_mode_i && idx_vld_i && idx_sel_i == SEL_SP) |=> err_o);

      // R4: narrow mode refuses a source-index register as base
      assert_narrow_base_refused_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (!wide_mode_i && base_vld_i && base_sel_i == SEL_SI) |=> err_o);

      // R5: scaling in narrow mode is refused
      assert_narrow_scale_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (!wide_mode_i && scale_i != '0) |=> err_o);

      // R6: narrow results keep the upper bits clear
      assert_narrow_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (!wide_mode_i) |=> (err_o || ea_o[AW-1:NW] == '0));

      // R7: a frame-pointer base selects the stack segment
      assert_bp_stack_seg_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (base_vld_i && base_sel_i == SEL_BP) |=> seg_o);

      // R1: no terms at all gives a zero address
      assert_empty_operand_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
         (wide_mode_i && !base_vld_i && !idx_vld_i && disp_sz_i == DSZ_NONE) |=> (ea_o == '0 || err_o));
   end else begin : g_comb
      assign ea_o  = ea_c;
      assign seg_o = stack_c;
      assign err_o = err_c;
   end
endmodule

// File: tb/test_ea_gen.sv
module test_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide;
   logic        bv;
   logic [2:0]  bs;
   logic        iv;
   logic [2:0]  is;
   logic [1:0]  sc;
   logic [31:0] disp;
   logic [1:0]  dsz;
   logic [31:0] bval;
   logic [31:0] ival;
   logic [31:0] ea;
   logic        seg;
   logic        err;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ea_gen i_ea_gen (
      .clk(clk), .rst_n(rst_n), .wide_mode_i(wide),
      .base_vld_i(bv), .base_sel_i(bs), .idx_vld_i(iv), .idx_sel_i(is),
      .scale_i(sc), .disp_i(disp), .disp_sz_i(dsz),
      .base_val_i(bval), .idx_val_i(ival),
      .ea_o(ea), .seg_o(seg), .err_o(err)
   );

   function automatic bit ref_err();
      bit e = 1'b0;
      if (dsz == 2'd3) e = 1'b1;
      if (sc != 2'd0 && (!wide || !iv)) e = 1'b1;
      if (wide) begin
         if (iv && is == 3'd4) e = 1'b1;
      end else begin
         if (bv && !(bs == 3'd3 || bs == 3'd5)) e = 1'b1;
         if (iv && !(is == 3'd6 || is == 3'd7)) e = 1'b1;
      end
      return e;
   endfunction

   function automatic string err_tag();
      if (dsz == 2'd3) return "R2";
      if (sc != 2'd0 && (!wide || !iv)) return "R5";
      if (wide) return "R3";
      return "R4";
   endfunction

   function automatic bit ref_seg();
      return bv && (bs == 3'd4 || bs == 3'd5);
   endfunction

   function automatic logic [31:0] ref_ea();
      logic [31:0] d;
      logic [31:0] s;
      case (dsz)
         2'd1:    d = {{24{disp[7]}}, disp[7:0]};
         2'd2:    d = wide ? disp : {16'h0, disp[15:0]};
         default: d = 32'h0;
      endcase
      s = (bv ? bval : 32'h0) + (iv ? (ival << sc) : 32'h0) + d;
      return wide ? s : {16'h0, s[15:0]};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(input bit w, input bit b_v, input logic [2:0] b_s,
                        input bit i_v, input logic [2:0] i_s, input logic [1:0] s,
                        input logic [31:0] d, input logic [1:0] dz,
                        input logic [31:0] b_val, input logic [31:0] i_val);
      logic [31:0] xe;
      bit xerr;
      bit xseg;
      string t;
      @(negedge clk);
      wide = w; bv = b_v; bs = b_s; iv = i_v; is = i_s; sc = s;
      disp = d; dsz = dz; bval = b_val; ival = i_val;
      xe = ref_ea(); xerr = ref_err(); xseg = ref_seg();
      t = xerr ? err_tag() : (w ? "R1" : "R6");
      @(negedge clk);
      check(t, {31'h0, err}, {31'h0, xerr});
      check("R7", {31'h0, seg}, {31'h0, xseg});
      if (!xerr) check(w ? "R1" : "R6", ea, xe);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed = 32'd12345;
      void'($urandom(seed));
      wide = 1; bv = 1; bs = 3'd5; iv = 1; is = 3'd6; sc = 2'd3;
      disp = 32'hffff_ffff; dsz = 2'd2; bval = 32'h1234_5678; ival = 32'h9;
      repeat (3) @(negedge clk);
      // R8: outputs held at zero in reset despite active inputs
      check("R8", ea, 32'h0);
      check("R8", {31'h0, seg}, 32'h0);
      check("R8", {31'h0, err}, 32'h0);
      rst_n = 1'b1;

      // R1: full wide sum with scale 8
      apply(1, 1, 3'd3, 1, 3'd6, 2'd3, 32'h0000_1000, 2'd2, 32'h1000_0000, 32'h10);
      // R2: byte displacement 0x80 is -128
      apply(1, 1, 3'd0, 0, 3'd0, 2'd0, 32'h0000_0080, 2'd1, 32'h0000_0100, 32'h0);
      // R2: code 0 ignores the displacement field
      apply(1, 1, 3'd1, 0, 3'd0, 2'd0, 32'hdead_beef, 2'd0, 32'h0000_4000, 32'h0);
      // R2: reserved size code
      apply(1, 1, 3'd1, 0, 3'd0, 2'd0, 32'h0, 2'd3, 32'h0, 32'h0);
      // R3: stack pointer as base is fine, as index refused
      apply(1, 1, 3'd4, 1, 3'd7, 2'd2, 32'h20, 2'd1, 32'h8000, 32'h4);
      apply(1, 1, 3'd0, 1, 3'd4, 2'd0, 32'h0, 2'd0, 32'h0, 32'h0);
      // R4: narrow base and index restrictions
      apply(0, 1, 3'd5, 1, 3'd7, 2'd0, 32'h0000_00fe, 2'd1, 32'h0001_fff0, 32'h0000_0005);
      apply(0, 1, 3'd0, 0, 3'd0, 2'd0, 32'h0, 2'd0, 32'h0, 32'h0);
      apply(0, 1, 3'd3, 1, 3'd2, 2'd0, 32'h0, 2'd0, 32'h0, 32'h0);
      // R5: scale with no index, and scale in narrow mode
      apply(1, 1, 3'd0, 0, 3'd0, 2'd1, 32'h0, 2'd0, 32'h0, 32'h0);
      apply(0, 1, 3'd3, 1, 3'd6, 2'd1, 32'h0, 2'd0, 32'h0, 32'h0);
      // R6: narrow wrap, full 16-bit displacement with upper bits set
      apply(0, 1, 3'd3, 1, 3'd6, 2'd0, 32'habcd_8000, 2'd2, 32'h0000_9000, 32'h0000_7001);
      // R7: no base means data segment
      apply(1, 0, 3'd5, 1, 3'd1, 2'd0, 32'h0, 2'd0, 32'h0, 32'h77);

      for (int n = 0; n < 600; n++) begin
         bit w = $urandom_range(0, 1) == 1;
         logic [2:0] b_s = 3'($urandom_range(0, 7));
         logic [2:0] i_s = 3'($urandom_range(0, 7));
         logic [1:0] s;
         logic [1:0] dz = 2'($urandom_range(0, 3));
         if (!w && $urandom_range(0, 3) != 0) begin
            b_s = ($urandom_range(0, 1) == 1) ? 3'd3 : 3'd5;
            i_s = ($urandom_range(0, 1) == 1) ? 3'd6 : 3'd7;
         end
         s = (!w && $urandom_range(0, 3) != 0) ? 2'd0 : 2'($urandom_range(0, 3));
         if (dz == 2'd3 && $urandom_range(0, 3) != 0) dz = 2'd2;
         apply(w, $urandom_range(0, 3) != 0, b_s, $urandom_range(0, 3) != 0, i_s, s,
               $urandom(), dz, $urandom(), $urandom());
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule